// File: doc/BRIEF.md
# Word Serializer with Realignable Elastic Store

This block turns a stream of 16-bit parallel words into a single serial bit stream. Words arrive on a parallel write clock and are caught in a holding register. They then cross through a four-entry elastic store into the fast bit-clock domain. A bit counter there produces a one-cycle load strobe in every sixteen bit clocks. On each strobe the next stored word drops into a shift register, which sends it out with its most significant bit first.

The write clock and the bit clock come from independent sources that run at matched rates, so the two store pointers hold a fixed distance only after a realignment. A rising edge on the phase-initialization input is synchronized into the bit domain. It then places the read pointer two entries behind the synchronized write pointer. A diagnostic loopback select, active low, routes the outgoing serial stream and the gated bit clock to the receive-side outputs instead of the external serial input. An active-low reset clears the holding register, every store entry, both pointers and the shifter, and it holds the output clocks low.

Top module: `word_serializer`

## Requirements
- R1: A word presented on `din_i` is captured on a rising edge of `wr_clk_i`. After a realignment, successive words leave the block in the order written, with none dropped and none repeated.
- R2: Each word is sent most significant bit first. In the sixteen bit-clock cycles after a load strobe, `ser_o` carries bit 15, then bit 14, down to bit 0.
- R3: `word_load_o` is high for exactly one bit-clock cycle in every sixteen. The last bit of a word is on `ser_o` in the same cycle as the strobe, and the new word's bit 15 follows in the next cycle.
- R4: A rising edge on `phinit_i` passes through a three-flop synchronizer in the bit domain and sets the read pointer two entries behind the synchronized write pointer. Afterwards the store never runs empty or over. When a word finishes on `ser_o`, between 2 and 7 newer words have been presented on `din_i`.
- R5: When `lpbk_n_i` is 0, `rx_data_o` follows `ser_o` and `rx_clk_o` follows `tx_clk_o`. `rx_ser_i` and `rx_clk_i` have no effect on either output.
- R6: When `lpbk_n_i` is 1, `rx_data_o` follows `rx_ser_i`, and `rx_clk_o` follows `rx_clk_i` once reset has been released.
- R7: While `rst_n_i` is 0, `ser_o` and `word_load_o` are 0, and `tx_clk_o` and `rx_clk_o` stay at 0 without toggling. All storage is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Parallel word clock; words are sampled on its rising edge |
| din_i | input | 16 | Parallel input word; bit 15 is sent first |
| bit_clk_i | input | 1 | Fast serial bit clock; read side of the store and the shifter |
| rst_n_i | input | 1 | Active-low master reset, asynchronous assert |
| phinit_i | input | 1 | Phase initialization; a rising edge re-centers the store |
| lpbk_n_i | input | 1 | Diagnostic loopback select, active low |
| rx_ser_i | input | 1 | External serial receive data |
| rx_clk_i | input | 1 | External receive bit clock |
| ser_o | output | 1 | Serial transmit data |
| tx_clk_o | output | 1 | Bit clock gated off during reset |
| word_load_o | output | 1 | One-cycle strobe marking the last bit of each word |
| rx_data_o | output | 1 | Serial data toward the receive deserializer |
| rx_clk_o | output | 1 | Bit clock toward the receive deserializer |

## Verification
On every cycle the assertions check several rules. The strobe must recur exactly sixteen bit clocks apart. The bit after a strobe must be bit 15 of the word the store presented, and each later bit must be the next lower one. After a realignment the store fill must stay within one entry of its center. The write pointer's Gray code must change one bit per word, and reset must keep the outputs quiet. The bench's scenarios are needed for what spans the clock crossing. They show that words arrive whole, in sequence and within a bounded lag after a phase-initialization pulse. They also show that the loopback select swaps both data and clock in either direction, and that a reset in mid-stream stops the output clocks.

// File: rtl/wser_pkg.sv
package wser_pkg;
  localparam int EST_AW = 2;
  localparam int EST_DEPTH = 1 << EST_AW;
  localparam int PTR_W = EST_AW + 1;

  typedef logic [PTR_W-1:0] ptr_t;

  function automatic ptr_t bin2gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(ptr_t g);
    ptr_t b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  function automatic ptr_t fill_of(ptr_t wr_bin, ptr_t rd_bin);
    return wr_bin - rd_bin;
  endfunction
endpackage

// File: rtl/wser_rst_sync.sv
module wser_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) q <= '0;
    else          q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = q[STAGES-1];
endmodule

// File: rtl/wser_edge_sync.sv
module wser_edge_sync #(
  parameter int STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) q <= '0;
    else          q <= {q[STAGES-2:0], async_i};
  end

  assign rise_o = q[STAGES-2] & ~q[STAGES-1];

  // R4: a realignment request lasts one cycle, however long the input stays high
  p_rise_single_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rise_o |=> !rise_o);
endmodule

// File: rtl/wser_estore.sv
module wser_estore
  import wser_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SYNC_N = 2,
  parameter int CENTER = 2
) (
  input  logic              wr_clk_i,
  input  logic              wr_rst_n_i,
  input  logic [WORD_W-1:0] din_i,
  input  logic              rd_clk_i,
  input  logic              rd_rst_n_i,
  input  logic              rd_adv_i,
  input  logic              realign_i,
  output logic [WORD_W-1:0] rd_word_o
);
  localparam ptr_t C_MID = ptr_t'(CENTER);
  localparam ptr_t C_LO  = ptr_t'(CENTER - 1);
  localparam ptr_t C_HI  = ptr_t'(CENTER + 1);

  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] mem_q [EST_DEPTH];
  ptr_t wr_bin_q, wr_gray_q;
  ptr_t wr_sync_q [SYNC_N];
  ptr_t wr_sync_bin, rd_bin_q, fill;
  logic aligned_q;

  // write side: holding register, then store entry
  always_ff @(posedge wr_clk_i or negedge wr_rst_n_i) begin
    if (!wr_rst_n_i) begin
      hold_q    <= '0;
      wr_bin_q  <= '0;
      wr_gray_q <= '0;
      for (int i = 0; i < EST_DEPTH; i++) mem_q[i] <= '0;
    end else begin
      hold_q                       <= din_i;
      mem_q[wr_bin_q[EST_AW-1:0]]  <= hold_q;
      wr_bin_q                     <= wr_bin_q + 1'b1;
      wr_gray_q                    <= bin2gray(wr_bin_q + 1'b1);
    end
  end

  // read side: Gray pointer synchronizer
  always_ff @(posedge rd_clk_i or negedge rd_rst_n_i) begin
    if (!rd_rst_n_i) begin
      for (int i = 0; i < SYNC_N; i++) wr_sync_q[i] <= '0;
    end else begin
      wr_sync_q[0] <= wr_gray_q;
      for (int i = 1; i < SYNC_N; i++) wr_sync_q[i] <= wr_sync_q[i-1];
    end
  end

  assign wr_sync_bin = gray2bin(wr_sync_q[SYNC_N-1]);
  assign fill        = fill_of(wr_sync_bin, rd_bin_q);

  always_ff @(posedge rd_clk_i or negedge rd_rst_n_i) begin
    if (!rd_rst_n_i) begin
      rd_bin_q  <= '0;
      aligned_q <= 1'b0;
    end else if (realign_i) begin
      rd_bin_q  <= wr_sync_bin - C_MID;
      aligned_q <= 1'b1;
    end else if (rd_adv_i) begin
      rd_bin_q  <= rd_bin_q + 1'b1;
    end
  end

  assign rd_word_o = mem_q[rd_bin_q[EST_AW-1:0]];

  // R1: the write pointer moves by one Gray step per word
  p_gray_step_r1: assert property (@(posedge wr_clk_i) disable iff (!wr_rst_n_i)
    $past(wr_rst_n_i) |-> $countones(wr_gray_q ^ $past(wr_gray_q)) == 1);

  // R4: just after realignment the fill sits at its center (or one above)
  p_realign_center_r4: assert property (@(posedge rd_clk_i) disable iff (!rd_rst_n_i)
    realign_i |=> (fill == C_MID || fill == C_HI));

  // R4: every read after alignment finds a written entry and no overrun
  p_fill_window_r4: assert property (@(posedge rd_clk_i) disable iff (!rd_rst_n_i)
    (rd_adv_i && aligned_q && !realign_i) |-> (fill >= C_LO && fill <= C_HI));
endmodule

// File: rtl/wser_shifter.sv
module wser_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ld_o,
  output logic              ser_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int GAP_W = CNT_W + 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic [GAP_W-1:0]  gap_q;

  assign ld_o  = (cnt_q == CNT_W'(WORD_W - 1));
  assign ser_o = sh_q[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= ld_o ? '0 : cnt_q + 1'b1;
      sh_q  <= ld_o ? word_i : {sh_q[WORD_W-2:0], 1'b0};
    end
  end

  // checker-side bit-clock count between strobes
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)  gap_q <= '0;
    else if (ld_o) gap_q <= '0;
    else           gap_q <= gap_q + 1'b1;
  end

  // R3: strobes are spaced one word apart
  p_ld_spacing_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ld_o |-> gap_q == GAP_W'(WORD_W - 1));

  p_ld_single_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ld_o |=> !ld_o);

  // R2: first bit after a strobe is the top bit of the presented word
  p_msb_first_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ld_o |=> ser_o == $past(word_i[WORD_W-1]));

  // R2: later bits step down one position per clock
  p_bit_order_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !ld_o |=> ser_o == $past(sh_q[WORD_W-2]));
endmodule

// File: rtl/word_serializer.sv
module word_serializer #(
  parameter int WORD_W    = 16,
  parameter int PTR_SYNC  = 2,
  parameter int EDGE_SYNC = 3,
  parameter int CENTER    = 2
) (
  input  logic              wr_clk_i,
  input  logic [WORD_W-1:0] din_i,
  input  logic              bit_clk_i,
  input  logic              rst_n_i,
  input  logic              phinit_i,
  input  logic              lpbk_n_i,
  input  logic              rx_ser_i,
  input  logic              rx_clk_i,
  output logic              ser_o,
  output logic              tx_clk_o,
  output logic              word_load_o,
  output logic              rx_data_o,
  output logic              rx_clk_o
);
  logic wr_rst_n, bit_rst_n;
  logic realign;
  logic [WORD_W-1:0] rd_word;

  wser_rst_sync #(.STAGES(2)) u_wr_rst (
    .clk_i(wr_clk_i), .rst_n_i(rst_n_i), .rst_n_o(wr_rst_n));

  wser_rst_sync #(.STAGES(2)) u_bit_rst (
    .clk_i(bit_clk_i), .rst_n_i(rst_n_i), .rst_n_o(bit_rst_n));

  wser_edge_sync #(.STAGES(EDGE_SYNC)) u_phinit (
    .clk_i(bit_clk_i), .rst_n_i(bit_rst_n), .async_i(phinit_i), .rise_o(realign));

  wser_estore #(.WORD_W(WORD_W), .SYNC_N(PTR_SYNC), .CENTER(CENTER)) u_store (
    .wr_clk_i  (wr_clk_i),
    .wr_rst_n_i(wr_rst_n),
    .din_i     (din_i),
    .rd_clk_i  (bit_clk_i),
    .rd_rst_n_i(bit_rst_n),
    .rd_adv_i  (word_load_o),
    .realign_i (realign),
    .rd_word_o (rd_word));

  wser_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (bit_clk_i),
    .rst_n_i(bit_rst_n),
    .word_i (rd_word),
    .ld_o   (word_load_o),
    .ser_o  (ser_o));

  // output clocks are held low while reset is active
  assign tx_clk_o  = bit_clk_i & bit_rst_n;
  assign rx_clk_o  = (lpbk_n_i ? rx_clk_i : bit_clk_i) & bit_rst_n;
  assign rx_data_o = lpbk_n_i ? rx_ser_i : ser_o;

  // R7: reset keeps the serial side quiet
  p_rst_quiet_r7: assert property (@(posedge bit_clk_i)
    !rst_n_i |-> (!ser_o && !word_load_o && !tx_clk_o && !rx_clk_o));
endmodule

// File: tb/word_serializer_bench.sv
module word_serializer_bench;
  logic        wr_clk = 1'b0, bit_clk = 1'b0;
  logic        rst_n = 1'b0, phinit = 1'b0, lpbk_n = 1'b1;
  logic        rx_ser = 1'b0, rx_clk = 1'b1;
  logic [15:0] din = '0;
  logic        ser_o, tx_clk_o, word_load_o, rx_data_o, rx_clk_o;

  int checks = 0, errors = 0, widx = 0;
  bit done = 1'b0;

  // loopback vectors: {lpbk_n, rx_ser, rx_clk}
  localparam logic [2:0] LB_VEC [8] = '{3'b100, 3'b110, 3'b101, 3'b111,
                                         3'b000, 3'b011, 3'b001, 3'b010};

  word_serializer u_word_serializer (
    .wr_clk_i(wr_clk), .din_i(din), .bit_clk_i(bit_clk), .rst_n_i(rst_n),
    .phinit_i(phinit), .lpbk_n_i(lpbk_n), .rx_ser_i(rx_ser), .rx_clk_i(rx_clk),
    .ser_o(ser_o), .tx_clk_o(tx_clk_o), .word_load_o(word_load_o),
    .rx_data_o(rx_data_o), .rx_clk_o(rx_clk_o));

  always #4 bit_clk = ~bit_clk;                  // 125 MHz
  initial begin #37; forever #64 wr_clk = ~wr_clk; end

  // upper byte is a sequence number, lower byte an asymmetric check code
  function automatic logic [15:0] mk(int k);
    logic [7:0] a;
    a = k[7:0];
    return {a, a ^ 8'h1E};
  endfunction

  always @(posedge wr_clk) begin
    #1;
    din = mk(widx);
    widx++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sync_ld();
    do @(negedge bit_clk); while (!word_load_o);
  endtask

  task automatic get_word(input bit use_rx, output logic [15:0] w, output bit ld_ok);
    w = '0;
    ld_ok = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge bit_clk);
      w = {w[14:0], use_rx ? rx_data_o : ser_o};
      if ((i == 15) != word_load_o) ld_ok = 1'b0;
    end
  endtask

  task automatic check_stream(input bit use_rx, input int n, input string req);
    logic [15:0] prev, w;
    bit ok;
    int lag;
    sync_ld();
    get_word(use_rx, prev, ok);
    for (int j = 0; j < n; j++) begin
      get_word(use_rx, w, ok);
      lag = (widx - int'(w[15:8])) & 255;
      check(w[7:0] == (w[15:8] ^ 8'h1E), "R2", {req, " msb-first code"}, w, {w[15:8], w[15:8] ^ 8'h1E});
      check(ok, "R3", {req, " strobe on last bit"}, ok, 1);
      check(w[15:8] == prev[15:8] + 8'd1, "R1", {req, " word order"}, w[15:8], prev[15:8] + 8'd1);
      check(lag >= 2 && lag <= 7, "R4", {req, " lag after realign"}, lag, 4);
      prev = w;
    end
  endtask

  task automatic pulse_phinit();
    @(negedge bit_clk) phinit = 1'b1;
    repeat (10) @(negedge bit_clk);
    phinit = 1'b0;
    repeat (6) @(posedge wr_clk);
  endtask

  initial begin
    // reset state (R7)
    for (int i = 0; i < 4; i++) begin
      @(posedge bit_clk); #1;
      check(tx_clk_o == 1'b0, "R7", "tx_clk_o held in reset", tx_clk_o, 0);
      check(rx_clk_o == 1'b0, "R7", "rx_clk_o held in reset", rx_clk_o, 0);
      check(ser_o == 1'b0 && word_load_o == 1'b0, "R7", "outputs quiet in reset",
            {ser_o, word_load_o}, 0);
    end
    @(negedge bit_clk) rst_n = 1'b1;
    repeat (4) @(posedge wr_clk);

    // realign, then stream through the direct path (R1..R4)
    pulse_phinit();
    check_stream(1'b0, 12, "direct");

    // loopback select table (R5, R6)
    foreach (LB_VEC[i]) begin
      @(negedge bit_clk);
      {lpbk_n, rx_ser, rx_clk} = LB_VEC[i];
      #1;
      if (lpbk_n) begin
        check(rx_data_o == rx_ser, "R6", "external data passed", rx_data_o, rx_ser);
        check(rx_clk_o == rx_clk, "R6", "external clock passed (low phase)", rx_clk_o, rx_clk);
      end else begin
        check(rx_data_o == ser_o, "R5", "loopback data", rx_data_o, ser_o);
        check(rx_clk_o == 1'b0, "R5", "loopback clock low phase", rx_clk_o, 0);
      end
      #4;
      if (lpbk_n)
        check(rx_clk_o == rx_clk, "R6", "external clock passed (high phase)", rx_clk_o, rx_clk);
      else
        check(rx_clk_o == tx_clk_o && rx_clk_o == 1'b1, "R5", "loopback clock high phase",
              rx_clk_o, tx_clk_o);
    end

    // words decoded from the receive side in loopback, with garbage on the external input
    lpbk_n = 1'b0; rx_ser = 1'b1; rx_clk = 1'b0;
    check_stream(1'b1, 6, "loopback R5");

    // second realignment while streaming keeps the stream whole
    lpbk_n = 1'b1;
    pulse_phinit();
    check_stream(1'b0, 6, "re-realign");

    // reset in mid-stream (R7)
    @(negedge bit_clk) rst_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      #2;
      check(tx_clk_o == 1'b0 && rx_clk_o == 1'b0, "R7", "clocks stopped mid-run reset",
            {tx_clk_o, rx_clk_o}, 0);
      check(ser_o == 1'b0 && word_load_o == 1'b0, "R7", "shifter cleared", {ser_o, word_load_o}, 0);
    end
    rst_n = 1'b1;
    repeat (4) @(posedge wr_clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule